// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings one or two DDR2 ranks from power-on to normal operation. From reset it keeps the clock-enable line low. It counts out a programmable stable-clock interval and waits for the PHY delay-locked loop to report lock. It then walks a fixed list of commands for each rank. The list brings up the clock enable, precharges all banks and programs the extended and base mode registers. It issues the refresh pair and runs the off-chip-driver calibration default and exit writes. Each command goes onto a 32-bit command word together with a one-cycle valid strobe.

A downstream command port accepts commands with a ready signal. The sequencer holds the pending command while ready is low. It keeps a minimum spacing between commands and stretches two of the gaps to the long waits the memory needs. When every rank has been programmed, it raises the flag that lets the controller's refresh engine run, and it raises a done flag. The rank count is taken from an input at the moment the sequence starts.

Top module: `ddr2_init_seq`

## Requirements
- R1: `cke_o` is 0 from reset. It goes to 1 in the same cycle that the first NOP command is presented on `cmd_o` with `cmd_valid_o`. It then stays 1 until the next reset.
- R2: No command is presented before `phy_locked_i` has been seen high. The first command appears at least two clocks after lock is first sampled.
- R3: The first command appears no earlier than `PWRUP_CYCLES` clocks after reset is released.
- R4: After the NOP of each rank, the next command follows at least max(`CKE_WAIT_CYCLES`, `CMD_GAP_CYCLES`) clocks later.
- R5: Each rank receives exactly 12 commands, in this order: NOP, precharge-all, write EMR2, write EMR3, EMR write of 0x400, MR write of 0x542, precharge-all, refresh, refresh, MR write of 0x442, EMR write of 0x780, EMR write of 0x400. The command word fields are as follows. Bits 27:24 hold the opcode: 0x7 NOP, 0x1 precharge-all, 0x5 refresh, 0x0 mode-register write. Bits 17:16 select the register: 0 MR, 1 EMR, 2 EMR2, 3 EMR3. Bits 15:0 hold the register value, which is 0 for EMR2 and EMR3. Every other bit is 0 except bit 20.
- R6: After the MR write of 0x442, the next command follows at least max(`MRS_WAIT_CYCLES`, `CMD_GAP_CYCLES`) clocks later.
- R7: Any two consecutive commands are at least `CMD_GAP_CYCLES` clocks apart. `cmd_valid_o` is never high in two adjacent cycles.
- R8: A command is presented only if `cmd_ready_i` was high in the cycle before. While ready is low, no command is presented.
- R9: With `two_chips_i` high when the sequence starts, the 12-command list runs for rank 0 and then again for rank 1. Bit 20 of the command word is 0 for rank 0 and 1 for rank 1. Changes on `two_chips_i` after the first command have no effect on the list.
- R10: `aref_en_o` and `init_done_o` are 0 while any command remains. Both go to 1 after the last command of the last rank and stay 1.
- R11: Asserting `rst` in the middle of a sequence drives `cke_o`, `cmd_valid_o`, `aref_en_o` and `init_done_o` to 0 on the next clock. A later release runs the whole sequence again from the stable-clock wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phy_locked_i | input | 1 | PHY DLL lock indication |
| two_chips_i | input | 1 | Initialize two ranks when high (sampled at sequence start) |
| cmd_ready_i | input | 1 | Command port can accept a command |
| cmd_valid_o | output | 1 | One-cycle strobe marking a command on `cmd_o` |
| cmd_o | output | 32 | Command word: opcode, rank bit, register select, value |
| cke_o | output | 1 | Clock-enable level for the memory |
| aref_en_o | output | 1 | Enables the controller's automatic refresh |
| init_done_o | output | 1 | Initialization complete |

## Verification
A corrupted step or rank pointer shows up as a wrong command word, and it shows on the very strobe where the pointer goes wrong. A wait counter that is loaded short shows as a time between strobes that is shorter than the rule requires, and it shows at the strobe that ends that wait. A lost rank-count latch shows as a sequence that ends after 12 commands or runs past them. A mis-set finish flag raises the refresh enable while commands are still outstanding. The scoreboard time-stamps every strobe, so each of these faults appears within one command of the defect.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

    localparam int CMD_W          = 32;
    localparam int STEPS_PER_RANK = 12;
    localparam int STEP_W         = 4;

    typedef enum logic [3:0] {
        OP_MRW  = 4'h0,
        OP_PALL = 4'h1,
        OP_AREF = 4'h5,
        OP_NOP  = 4'h7
    } op_e;

    typedef enum logic [1:0] {
        MR_BASE = 2'd0,
        MR_EXT1 = 2'd1,
        MR_EXT2 = 2'd2,
        MR_EXT3 = 2'd3
    } mr_sel_e;

    typedef struct packed {
        logic [3:0]  rsvd_hi;
        op_e         op;
        logic [2:0]  rsvd_mid;
        logic        rank;
        logic [1:0]  rsvd_lo;
        mr_sel_e     mr;
        logic [15:0] val;
    } cmd_t;

    typedef enum logic [1:0] {
        GAP_PLAIN,
        GAP_CKE,
        GAP_MRS
    } gap_e;

    typedef enum logic [1:0] {
        ST_PWR,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } st_e;

    function automatic int max_i(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic cmd_t mk_cmd(op_e op, mr_sel_e mr, logic [15:0] val, logic rank);
        cmd_t c;
        c          = '0;
        c.op       = op;
        c.mr       = mr;
        c.val      = val;
        c.rank     = rank;
        return c;
    endfunction

    function automatic cmd_t step_cmd(logic [STEP_W-1:0] step, logic rank);
        case (step)
            4'd0:    return mk_cmd(OP_NOP,  MR_BASE, 16'h0000, rank);
            4'd1:    return mk_cmd(OP_PALL, MR_BASE, 16'h0000, rank);
            4'd2:    return mk_cmd(OP_MRW,  MR_EXT2, 16'h0000, rank);
            4'd3:    return mk_cmd(OP_MRW,  MR_EXT3, 16'h0000, rank);
            4'd4:    return mk_cmd(OP_MRW,  MR_EXT1, 16'h0400, rank);
            4'd5:    return mk_cmd(OP_MRW,  MR_BASE, 16'h0542, rank);
            4'd6:    return mk_cmd(OP_PALL, MR_BASE, 16'h0000, rank);
            4'd7:    return mk_cmd(OP_AREF, MR_BASE, 16'h0000, rank);
            4'd8:    return mk_cmd(OP_AREF, MR_BASE, 16'h0000, rank);
            4'd9:    return mk_cmd(OP_MRW,  MR_BASE, 16'h0442, rank);
            4'd10:   return mk_cmd(OP_MRW,  MR_EXT1, 16'h0780, rank);
            default: return mk_cmd(OP_MRW,  MR_EXT1, 16'h0400, rank);
        endcase
    endfunction

    function automatic gap_e step_gap(logic [STEP_W-1:0] step);
        case (step)
            4'd0:    return GAP_CKE;
            4'd9:    return GAP_MRS;
            default: return GAP_PLAIN;
        endcase
    endfunction

endpackage

// File: rtl/ddr2i_pwrup_timer.sv
module ddr2i_pwrup_timer #(
    parameter int CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(CYCLES - 1))
                done_o <= 1'b1;
        end
    end

    p_pwr_count_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(cnt_q) == CW'(CYCLES - 1));

endmodule

// File: rtl/ddr2i_delay.sv
module ddr2i_delay #(
    parameter int MAXV = 200
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_i,
    input  logic [$clog2(MAXV+1)-1:0]    val_i,
    output logic                         expired_o
);
    localparam int TW = $clog2(MAXV + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    p_delay_bound_r7: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= TW'(MAXV));

    p_delay_down_r7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/ddr2i_step_gen.sv
module ddr2i_step_gen
    import ddr2i_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    input  logic two_ranks_i,
    output cmd_t cmd_o,
    output gap_e gap_o,
    output logic last_o
);
    logic [STEP_W-1:0] step_q;
    logic              rank_q;
    logic              end_of_rank;

    assign end_of_rank = (step_q == STEP_W'(STEPS_PER_RANK - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
            rank_q <= 1'b0;
        end else if (adv_i) begin
            if (end_of_rank) begin
                step_q <= '0;
                rank_q <= 1'b1;
            end else begin
                step_q <= step_q + 1'b1;
            end
        end
    end

    assign cmd_o  = step_cmd(step_q, rank_q);
    assign gap_o  = step_gap(step_q);
    assign last_o = end_of_rank && (rank_q || !two_ranks_i);

    p_step_range_r5: assert property (@(posedge clk) disable iff (rst)
        step_q < STEP_W'(STEPS_PER_RANK));

    p_rank_order_r9: assert property (@(posedge clk) disable iff (rst)
        (adv_i && end_of_rank) |=> (step_q == '0 && rank_q));

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int PWRUP_CYCLES    = 10000,
    parameter int CKE_WAIT_CYCLES = 20,
    parameter int MRS_WAIT_CYCLES = 200,
    parameter int CMD_GAP_CYCLES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phy_locked_i,
    input  logic              two_chips_i,
    input  logic              cmd_ready_i,
    output logic              cmd_valid_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              cke_o,
    output logic              aref_en_o,
    output logic              init_done_o
);
    localparam int W_PLAIN = max_i(CMD_GAP_CYCLES, 1);
    localparam int W_CKE   = max_i(W_PLAIN, CKE_WAIT_CYCLES);
    localparam int W_MRS   = max_i(W_PLAIN, MRS_WAIT_CYCLES);
    localparam int W_MAX   = max_i(W_CKE, W_MRS);
    localparam int TW      = $clog2(W_MAX + 1);

    st_e           state_q;
    logic          two_q;
    logic          fin_q;
    logic          pwr_done;
    logic          issue;
    logic          wait_over;
    cmd_t          cur_cmd;
    gap_e          cur_gap;
    logic          cur_last;
    logic [TW-1:0] wait_len;

    ddr2i_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_pwr (
        .clk    (clk),
        .rst    (rst),
        .done_o (pwr_done)
    );

    assign issue = (state_q == ST_ISSUE) && cmd_ready_i;

    ddr2i_step_gen u_steps (
        .clk         (clk),
        .rst         (rst),
        .adv_i       (issue),
        .two_ranks_i (two_q),
        .cmd_o       (cur_cmd),
        .gap_o       (cur_gap),
        .last_o      (cur_last)
    );

    always_comb begin
        case (cur_gap)
            GAP_CKE: wait_len = TW'(W_CKE - 1);
            GAP_MRS: wait_len = TW'(W_MRS - 1);
            default: wait_len = TW'(W_PLAIN - 1);
        endcase
    end

    ddr2i_delay #(.MAXV(W_MAX)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .load_i    (issue),
        .val_i     (wait_len),
        .expired_o (wait_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_PWR;
            two_q       <= 1'b0;
            fin_q       <= 1'b0;
            cmd_valid_o <= 1'b0;
            cmd_o       <= '0;
            cke_o       <= 1'b0;
            aref_en_o   <= 1'b0;
            init_done_o <= 1'b0;
        end else begin
            cmd_valid_o <= 1'b0;
            case (state_q)
                ST_PWR: begin
                    if (pwr_done && phy_locked_i) begin
                        two_q   <= two_chips_i;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready_i) begin
                        cmd_valid_o <= 1'b1;
                        cmd_o       <= cur_cmd;
                        if (cur_cmd.op == OP_NOP)
                            cke_o <= 1'b1;
                        fin_q   <= cur_last;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_over) begin
                        if (fin_q) begin
                            aref_en_o   <= 1'b1;
                            init_done_o <= 1'b1;
                            state_q     <= ST_DONE;
                        end else begin
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_DONE;
            endcase
        end
    end

    p_cke_rise_nop_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_o) |-> (cmd_valid_o && cmd_o[27:24] == 4'h7));

    p_cke_hold_r1: assert property (@(posedge clk) disable iff (rst)
        cke_o |=> cke_o);

    p_pwr_before_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> pwr_done);

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);

    p_ready_gate_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> $past(cmd_ready_i));

    p_aref_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> !aref_en_o);

    p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
        init_done_o |=> (init_done_o && aref_en_o));

endmodule

// File: tb/tb_ddr2_init_seq.sv
module tb_ddr2_init_seq;

    localparam int PW   = 500;
    localparam int CKEW = 20;
    localparam int MRSW = 200;
    localparam int GAP  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phy_locked_i = 1'b0;
    logic        two_chips_i = 1'b0;
    logic        cmd_ready_i = 1'b1;
    logic        cmd_valid_o;
    logic [31:0] cmd_o;
    logic        cke_o;
    logic        aref_en_o;
    logic        init_done_o;

    always #10 clk = ~clk;

    ddr2_init_seq #(
        .PWRUP_CYCLES(PW), .CKE_WAIT_CYCLES(CKEW),
        .MRS_WAIT_CYCLES(MRSW), .CMD_GAP_CYCLES(GAP)
    ) dut (
        .clk(clk), .rst(rst), .phy_locked_i(phy_locked_i),
        .two_chips_i(two_chips_i), .cmd_ready_i(cmd_ready_i),
        .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o), .cke_o(cke_o),
        .aref_en_o(aref_en_o), .init_done_o(init_done_o)
    );

    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] exp_q[$];
    int          exp_pos = 0;
    int          last_stamp = 0;
    int          rel_cyc = 0;
    int          lock_cyc = 0;
    bit          mon_en = 0;
    bit          stall_en = 0;
    bit          prev_ready = 1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic void chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic logic [31:0] exp_word(int k, bit rank);
        logic [31:0] w;
        case (k)
            0:  w = 32'h0700_0000;
            1:  w = 32'h0100_0000;
            2:  w = 32'h0002_0000;
            3:  w = 32'h0003_0000;
            4:  w = 32'h0001_0400;
            5:  w = 32'h0000_0542;
            6:  w = 32'h0100_0000;
            7:  w = 32'h0500_0000;
            8:  w = 32'h0500_0000;
            9:  w = 32'h0000_0442;
            10: w = 32'h0001_0780;
            default: w = 32'h0001_0400;
        endcase
        return w | (rank ? 32'h0010_0000 : 32'h0);
    endfunction

    task automatic push_seq(bit two);
        exp_q.delete();
        for (int r = 0; r < (two ? 2 : 1); r++)
            for (int k = 0; k < 12; k++)
                exp_q.push_back(exp_word(k, r[0]));
    endtask

    // ready pattern driver
    initial forever begin
        @(posedge clk); #2;
        cmd_ready_i = stall_en ? ((cyc % 5) != 0 && (cyc % 7) != 3) : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_en) begin
            if (cmd_valid_o) begin
                chk(prev_ready, "R8", "valid without ready", 0, 1);
                chk(!aref_en_o, "R10", "refresh enabled during init", aref_en_o, 0);
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected extra command", cmd_o, 0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(cmd_o == e, (exp_pos >= 12) ? "R9" : "R5", "command word", cmd_o, e);
                    if (exp_pos == 0) begin
                        chk(cyc - rel_cyc >= PW, "R3", "power-up wait", cyc - rel_cyc, PW);
                        chk(cyc >= lock_cyc + 2, "R2", "command before lock", cyc, lock_cyc + 2);
                        chk(cke_o == 1'b1, "R1", "cke with first NOP", cke_o, 1);
                    end else begin
                        int p;
                        int d;
                        p = (exp_pos - 1) % 12;
                        d = cyc - last_stamp;
                        if (p == 0)
                            chk(d >= CKEW, "R4", "wait after NOP", d, CKEW);
                        else if (p == 9)
                            chk(d >= MRSW, "R6", "wait after MRS", d, MRSW);
                        else
                            chk(d >= GAP, "R7", "command gap", d, GAP);
                    end
                    exp_pos++;
                end
                last_stamp = cyc;
            end else if (exp_pos == 0) begin
                chk(cke_o == 1'b0, "R1", "cke before NOP", cke_o, 0);
            end
        end
        prev_ready = cmd_ready_i;
    end

    task automatic run_seq(bit two, int lock_delay, bit stall, int abort_after);
        int total;
        total = two ? 24 : 12;
        mon_en = 0;
        @(posedge clk); #2;
        rst = 1; phy_locked_i = 0; stall_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!cke_o && !cmd_valid_o, "R11", "reset cke/valid", {cke_o, cmd_valid_o}, 0);
        chk(!aref_en_o && !init_done_o, "R10", "reset flags", {aref_en_o, init_done_o}, 0);
        push_seq(two);
        exp_pos = 0;
        two_chips_i = two;
        phy_locked_i = (lock_delay == 0);
        @(posedge clk); #2;
        rst = 0;
        rel_cyc = cyc;
        lock_cyc = rel_cyc - 2;
        stall_en = stall;
        mon_en = 1;
        for (int i = 0; i < 60000 && !init_done_o; i++) begin
            @(posedge clk); #2;
            if (lock_delay > 0 && i == lock_delay) begin
                phy_locked_i = 1;
                lock_cyc = cyc;
            end
            if (two && exp_pos >= 1) two_chips_i = 0;
            if (abort_after > 0 && exp_pos >= abort_after) break;
        end
        if (abort_after > 0) begin
            rst = 1;
            mon_en = 0;
            @(posedge clk);
            @(negedge clk);
            chk(!cke_o && !cmd_valid_o, "R11", "mid-run reset cke/valid", {cke_o, cmd_valid_o}, 0);
            chk(!aref_en_o && !init_done_o, "R11", "mid-run reset flags", {aref_en_o, init_done_o}, 0);
            return;
        end
        @(negedge clk);
        chk(init_done_o && aref_en_o, "R10", "done and refresh after last", {init_done_o, aref_en_o}, 2'b11);
        chk(exp_pos == total, two ? "R9" : "R5", "command count", exp_pos, total);
        repeat (8) @(negedge clk);
        chk(init_done_o && aref_en_o, "R10", "flags stay high", {init_done_o, aref_en_o}, 2'b11);
        chk(cke_o, "R1", "cke stays high", cke_o, 1);
        stall_en = 0;
        mon_en = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        run_seq(0, 0,   0, 0);  // one rank, lock early
        run_seq(1, 0,   1, 0);  // two ranks, ready stalls, mode toggled late
        run_seq(0, 800, 0, 0);  // lock arrives after power-up wait (R2)
        run_seq(1, 0,   0, 7);  // reset in the middle (R11)
        run_seq(0, 0,   1, 0);  // full restart after abort
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule